// File: doc/BRIEF.md
# Write-Masked GPIO Register Bank

This block is the register file of a 32-pin general-purpose I/O bank, reached over a simple 32-bit memory-mapped bus with one write strobe and a combinational read port. Each 32-pin logical register is split into two half-word registers at adjacent word addresses. The upper 16 bits of every write are a per-bit enable for the lower 16 data bits. Software can therefore set or clear any single pin field with one store and no read-modify-write.

The bank holds eight stored configuration registers: output level, direction, interrupt enable, interrupt mask, interrupt type, interrupt polarity, both-edge select and debounce select. It drives the pin outputs and output enables. It hands the interrupt configuration to a separate edge/level detector and takes that detector's raw status back. It also gives read access to the synchronized pin levels, the raw status, the masked status and a fixed version word. A write to the end-of-interrupt location sends a one-cycle clear pulse per pin to the detector.

Top module: `gpio_wmask_bank`

## Requirements
- R1: While reset is asserted, and after it is released, all eight stored registers are zero. So `pin_oe`, `pin_out`, `eoi_clr` and all configuration outputs are zero, and every pin is an input.
- R2: A write to a stored half-word updates bit i (0..15) with `wdata[i]` only where `wdata[16+i]` is 1. Every other bit keeps its value. A write whose bits 31:16 are all zero changes nothing.
- R3: Pins 0..15 of a stored register sit at its base byte offset, and pins 16..31 at base+4. A read returns that half in `rdata[15:0]` with `rdata[31:16]` zero. The base offsets are 0x00 output level, 0x08 direction, 0x10 interrupt enable, 0x18 interrupt mask, 0x20 type, 0x28 polarity, 0x30 both-edge, 0x38 debounce.
- R4: `pin_oe[i]` equals direction bit i (1 = output, 0 = input), and `pin_out[i]` equals output-level bit i. Both update on the clock edge that takes the write.
- R5: A read of offset 0x78 returns 0x01000C2B.
- R6: Offsets 0x70/0x74 return the pin level after SYNC_STAGES clock edges (2 by default), whatever the pin's direction. The same value drives `pin_sync`.
- R7: Writes to the read-only locations 0x50/0x54, 0x58/0x5C and 0x70/0x74 change no state.
- R8: Offsets 0x58/0x5C read `raw_status`. Offsets 0x50/0x54 read, and `irq_status` drives, `raw_status & irq_en & ~irq_mask`.
- R9: Offsets 0x60/0x64 read zero. In the cycle after a write there, `eoi_clr` pulses for one cycle on each pin of that half whose data bit and enable bit are both 1. Otherwise `eoi_clr` is zero.
- R10: A read of any offset not listed above, including 0x7C, returns zero.
- R11: `irq_en`, `irq_mask`, `irq_type`, `irq_pol`, `irq_both` and `irq_deb` equal their stored registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data: [31:16] enables, [15:0] data |
| rdata | output | 32 | Combinational read data for `addr` |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_sync | output | 32 | Synchronized pin levels |
| pin_out | output | 32 | Output level per pin |
| pin_oe | output | 32 | Output enable per pin |
| raw_status | input | 32 | Raw interrupt status from the detector |
| irq_status | output | 32 | Enabled, unmasked status |
| irq_en | output | 32 | Interrupt enable per pin |
| irq_mask | output | 32 | Interrupt mask per pin |
| irq_type | output | 32 | Interrupt type per pin |
| irq_pol | output | 32 | Interrupt polarity per pin |
| irq_both | output | 32 | Both-edge select per pin |
| irq_deb | output | 32 | Debounce select per pin |
| eoi_clr | output | 32 | One-cycle clear pulse per pin |

## Verification
The assertions assume that `addr` and `wdata` are settled before each rising edge and that `wr_en` is never unknown outside reset. They also assume word-aligned addresses, so a write lands in exactly one half. The bench changes every input on the falling edge, uses only aligned offsets, and holds `raw_status` and `pin_in` steady while it reads the locations that reflect them. For this reason the properties never see a half-formed write or a read of a misaligned location.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam logic [31:0] BANK_VERSION = 32'h01000C2B;
   localparam int unsigned N_STORED     = 8;

   // slot = byte offset [6:3]; only slots 0..7 are stored
   typedef enum logic [3:0] {
      SLOT_LEVEL = 4'd0,
      SLOT_DIR   = 4'd1,
      SLOT_IEN   = 4'd2,
      SLOT_IMSK  = 4'd3,
      SLOT_ITYP  = 4'd4,
      SLOT_IPOL  = 4'd5,
      SLOT_IBTH  = 4'd6,
      SLOT_IDEB  = 4'd7,
      SLOT_STAT  = 4'd10,
      SLOT_RAW   = 4'd11,
      SLOT_EOI   = 4'd12,
      SLOT_EXT   = 4'd14,
      SLOT_VER   = 4'd15
   } slot_e;

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec #(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [3:0]        slot,
   output logic              hi,
   output logic              hit
);
   logic aligned;
   logic in_window;

   assign slot    = addr[6:3];
   assign hi      = addr[2];
   assign aligned = (addr[1:0] == 2'b00);

   generate
      if (ADDR_W > 7) begin : g_wide
         assign in_window = (addr[ADDR_W-1:7] == '0);
      end else begin : g_exact
         assign in_window = 1'b1;
      end
   endgenerate

   assign hit = aligned & in_window;
endmodule

// File: rtl/gpio_mask_half.sv
module gpio_mask_half #(
   parameter int HW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [HW-1:0] d,
   input  logic [HW-1:0] en,
   output logic [HW-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (we) begin
         q <= (q & ~en) | (d & en);
      end
   end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0][W-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= '0;
            end else begin
               chain[0] <= din;
               for (int s = 1; s < STAGES; s++) begin
                  chain[s] <= chain[s-1];
               end
            end
         end
         assign dout = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/gpio_wmask_bank.sv
module gpio_wmask_bank
   import gpio_bank_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [DATA_W-1:0] pin_in,
   output logic [DATA_W-1:0] pin_sync,
   output logic [DATA_W-1:0] pin_out,
   output logic [DATA_W-1:0] pin_oe,
   input  logic [DATA_W-1:0] raw_status,
   output logic [DATA_W-1:0] irq_status,
   output logic [DATA_W-1:0] irq_en,
   output logic [DATA_W-1:0] irq_mask,
   output logic [DATA_W-1:0] irq_type,
   output logic [DATA_W-1:0] irq_pol,
   output logic [DATA_W-1:0] irq_both,
   output logic [DATA_W-1:0] irq_deb,
   output logic [DATA_W-1:0] eoi_clr
);
   localparam int HW   = DATA_W / 2;
   localparam int PINS = DATA_W;
   localparam int NREG = N_STORED;

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("gpio_wmask_bank: DATA_W must be 32");
      end
      if (ADDR_W < 7) begin : g_bad_addr
         $error("gpio_wmask_bank: ADDR_W must be at least 7");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("gpio_wmask_bank: SYNC_STAGES out of range 0..4");
      end
   endgenerate

   logic [3:0] slot;
   logic       hi;
   logic       hit;

   gpio_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
      .addr (addr),
      .slot (slot),
      .hi   (hi),
      .hit  (hit)
   );

   gpio_in_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pin_in),
      .dout  (pin_sync)
   );

   // stored configuration, one masked half register per (slot, half)
   logic [NREG-1:0][PINS-1:0] store;
   logic [HW-1:0]             wr_d;
   logic [HW-1:0]             wr_m;

   assign wr_d = wdata[HW-1:0];
   assign wr_m = wdata[DATA_W-1:HW];

   generate
      for (genvar r = 0; r < NREG; r++) begin : g_reg
         for (genvar h = 0; h < 2; h++) begin : g_half
            logic sel;
            assign sel = wr_en & hit & (slot == 4'(r)) & (hi == 1'(h));
            gpio_mask_half #(.HW(HW)) u_half (
               .clk   (clk),
               .rst_n (rst_n),
               .we    (sel),
               .d     (wr_d),
               .en    (wr_m),
               .q     (store[r][h*HW +: HW])
            );
         end
      end
   endgenerate

   assign pin_out  = store[SLOT_LEVEL];
   assign pin_oe   = store[SLOT_DIR];
   assign irq_en   = store[SLOT_IEN];
   assign irq_mask = store[SLOT_IMSK];
   assign irq_type = store[SLOT_ITYP];
   assign irq_pol  = store[SLOT_IPOL];
   assign irq_both = store[SLOT_IBTH];
   assign irq_deb  = store[SLOT_IDEB];

   assign irq_status = raw_status & irq_en & ~irq_mask;

   // end-of-interrupt pulse, registered one cycle after the write
   logic          eoi_wr;
   logic [HW-1:0] eoi_bits;
   assign eoi_wr   = wr_en & hit & (slot == SLOT_EOI);
   assign eoi_bits = wr_d & wr_m;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eoi_clr <= '0;
      end else if (eoi_wr) begin
         eoi_clr <= hi ? {eoi_bits, {HW{1'b0}}} : {{HW{1'b0}}, eoi_bits};
      end else begin
         eoi_clr <= '0;
      end
   end

   // read path
   function automatic logic [HW-1:0] half_of(input logic [PINS-1:0] v,
                                             input logic            upper);
      return upper ? v[PINS-1:HW] : v[HW-1:0];
   endfunction

   logic [DATA_W-1:0] rd_word;
   always_comb begin
      rd_word = '0;
      if (hit) begin
         if (slot < 4'(NREG)) begin
            rd_word = {{HW{1'b0}}, half_of(store[slot[2:0]], hi)};
         end else begin
            case (slot)
               SLOT_STAT: rd_word = {{HW{1'b0}}, half_of(irq_status, hi)};
               SLOT_RAW:  rd_word = {{HW{1'b0}}, half_of(raw_status, hi)};
               SLOT_EXT:  rd_word = {{HW{1'b0}}, half_of(pin_sync, hi)};
               SLOT_VER:  rd_word = hi ? '0 : BANK_VERSION;
               default:   rd_word = '0;
            endcase
         end
      end
   end

   assign rdata = rd_word;
endmodule

// File: rtl/gpio_wmask_bank_chk.sv
module gpio_wmask_bank_chk #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic [DATA_W-1:0] pin_out,
   input logic [DATA_W-1:0] pin_oe,
   input logic [DATA_W-1:0] eoi_clr
);
   localparam int HW = DATA_W / 2;

   // R2: masked update of direction low half
   a_r2_masked_dir: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'('h08)) |=>
      pin_oe[HW-1:0] == (($past(pin_oe[HW-1:0]) & ~$past(wdata[DATA_W-1:HW]))
                        | ($past(wdata[HW-1:0]) & $past(wdata[DATA_W-1:HW]))));

   // R4: with no write, outputs hold
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(pin_oe) && $stable(pin_out)));

   // R7: writes to read-only pin-level locations leave outputs alone
   a_r7_ro_ext: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'('h70)) |=> ($stable(pin_oe) && $stable(pin_out)));

   // R9: pulse content after a low-half end-of-interrupt write
   a_r9_eoi_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'('h60)) |=>
      eoi_clr == {{HW{1'b0}}, $past(wdata[HW-1:0]) & $past(wdata[DATA_W-1:HW])});

   // R9: no pulse without an end-of-interrupt write
   a_r9_eoi_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (addr == ADDR_W'('h60) || addr == ADDR_W'('h64))) |=> eoi_clr == '0);

   // R5: version word
   a_r5_version: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_W'('h78)) |-> rdata == 32'h01000C2B);

   // R10: unmapped offset reads zero
   a_r10_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_W'('h40) || addr == ADDR_W'('h7C)) |-> rdata == '0);
endmodule

bind gpio_wmask_bank gpio_wmask_bank_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .addr    (addr),
   .wdata   (wdata),
   .rdata   (rdata),
   .pin_out (pin_out),
   .pin_oe  (pin_oe),
   .eoi_clr (eoi_clr)
);

// File: tb/tb_gpio_wmask_bank.sv
module tb_gpio_wmask_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_sync, pin_out, pin_oe;
   logic [31:0] raw_status = '0;
   logic [31:0] irq_status, irq_en, irq_mask, irq_type, irq_pol, irq_both, irq_deb, eoi_clr;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   gpio_wmask_bank dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .pin_in(pin_in), .pin_sync(pin_sync), .pin_out(pin_out),
      .pin_oe(pin_oe), .raw_status(raw_status), .irq_status(irq_status),
      .irq_en(irq_en), .irq_mask(irq_mask), .irq_type(irq_type), .irq_pol(irq_pol),
      .irq_both(irq_both), .irq_deb(irq_deb), .eoi_clr(eoi_clr)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
      @(negedge clk);
      addr = a;
      #1 chk(req, rdata, exp);
   endtask

   // {req, is_write, addr, data, expected}
   localparam int NV = 23;
   localparam logic [80:0] VEC [NV] = '{
      {8'd2,  1'b1, 8'h08, 32'hFFFF00F0, 32'h0},        // R2 full-mask write
      {8'd2,  1'b0, 8'h08, 32'h0,        32'h000000F0},
      {8'd2,  1'b1, 8'h08, 32'h00030001, 32'h0},        // R2 two-bit update
      {8'd2,  1'b0, 8'h08, 32'h0,        32'h000000F1},
      {8'd3,  1'b1, 8'h0C, 32'h80008000, 32'h0},        // R3 upper half
      {8'd3,  1'b0, 8'h0C, 32'h0,        32'h00008000},
      {8'd3,  1'b0, 8'h08, 32'h0,        32'h000000F1},
      {8'd2,  1'b1, 8'h00, 32'h00FF00AA, 32'h0},
      {8'd2,  1'b0, 8'h00, 32'h0,        32'h000000AA},
      {8'd2,  1'b1, 8'h00, 32'h00F00000, 32'h0},        // R2 clear bits 4..7
      {8'd2,  1'b0, 8'h00, 32'h0,        32'h0000000A},
      {8'd5,  1'b0, 8'h78, 32'h0,        32'h01000C2B}, // R5
      {8'd10, 1'b0, 8'h7C, 32'h0,        32'h0},        // R10
      {8'd10, 1'b0, 8'h40, 32'h0,        32'h0},        // R10
      {8'd9,  1'b0, 8'h60, 32'h0,        32'h0},        // R9 reads zero
      {8'd7,  1'b1, 8'h70, 32'hFFFFFFFF, 32'h0},        // R7 write ignored
      {8'd7,  1'b0, 8'h70, 32'h0,        32'h0},
      {8'd3,  1'b1, 8'h20, 32'hFFFF1234, 32'h0},
      {8'd3,  1'b0, 8'h20, 32'h0,        32'h00001234},
      {8'd3,  1'b1, 8'h3C, 32'h00FF005A, 32'h0},
      {8'd3,  1'b0, 8'h3C, 32'h0,        32'h0000005A},
      {8'd2,  1'b1, 8'h00, 32'h0000FFFF, 32'h0},        // R2 no enables
      {8'd2,  1'b0, 8'h00, 32'h0,        32'h0000000A}
   };

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      #1;
      chk("R1 pin_oe in reset", pin_oe, 32'h0);
      chk("R1 pin_out in reset", pin_out, 32'h0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      do_rd("R1 dir after reset", 8'h08, 32'h0);
      chk("R1 eoi_clr after reset", eoi_clr, 32'h0);

      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d vec%0d", VEC[i][80:73], i);
         if (VEC[i][72]) do_wr(VEC[i][71:64], VEC[i][63:32]);
         else            do_rd(tag, VEC[i][71:64], VEC[i][31:0]);
      end

      // R4 output pins follow stored registers
      chk("R4 pin_oe", pin_oe, 32'h800000F1);
      chk("R4 pin_out", pin_out, 32'h0000000A);
      // R11 configuration ports
      chk("R11 irq_type", irq_type, 32'h00001234);
      chk("R11 irq_deb", irq_deb, 32'h005A0000);

      // R8 status: en=0x00FF, mask=0x000F, raw=0x0FF3
      do_wr(8'h10, 32'hFFFF00FF);
      do_wr(8'h18, 32'h000F000F);
      raw_status = 32'h00000FF3;
      chk("R11 irq_en", irq_en, 32'h000000FF);
      chk("R11 irq_mask", irq_mask, 32'h0000000F);
      do_rd("R8 status lo", 8'h50, 32'h000000F0);
      chk("R8 irq_status", irq_status, 32'h000000F0);
      do_rd("R8 raw lo", 8'h58, 32'h00000FF3);
      do_rd("R8 status hi", 8'h54, 32'h0);
      raw_status = 32'h12340FF3;
      do_rd("R8 raw hi", 8'h5C, 32'h00001234);
      do_wr(8'h58, 32'hFFFF0000);                       // R7 ignored
      do_rd("R7 raw after write", 8'h58, 32'h00000FF3);
      do_wr(8'h50, 32'hFFFFFFFF);
      chk("R7 enable unchanged", irq_en, 32'h000000FF);

      // R9 end-of-interrupt pulse on the upper half
      @(negedge clk);
      wr_en = 1'b1; addr = 8'h64; wdata = 32'h0F0F00FF;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R9 eoi pulse", eoi_clr, 32'h000F0000);
      @(negedge clk);
      chk("R9 eoi one cycle", eoi_clr, 32'h0);
      do_wr(8'h60, 32'h000000FF);                       // no enables -> no pulse
      chk("R9 eoi no enable", eoi_clr, 32'h0);

      // R6 synchronized input, live on output pins too
      @(negedge clk);
      pin_in = 32'hA5A50F0F; addr = 8'h70;
      @(negedge clk);
      #1 chk("R6 one edge still old", rdata, 32'h0);
      @(negedge clk);
      #1 chk("R6 after two edges", rdata, 32'h00000F0F);
      chk("R6 pin_sync", pin_sync, 32'hA5A50F0F);
      do_rd("R6 upper half", 8'h74, 32'h0000A5A5);

      // R1 reset mid-run clears stored state
      @(negedge clk);
      rst_n = 1'b0;
      #1 chk("R1 pin_oe cleared", pin_oe, 32'h0);
      chk("R1 irq_type cleared", irq_type, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      do_rd("R1 level after reset", 8'h00, 32'h0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule